// File: doc/BRIEF.md
# Keyed Oscillator Control Register Bank

This block is the register bank that sits between an APB bus and a ring-oscillator controller. Software reaches enable, frequency range, per-stage drive strength, a randomiser seed, a pause request, an output divider and a phase-shifted output through it. Every field that changes oscillator behaviour takes effect only when the written word carries a recognised key or code word. This makes a stray or corrupted store unlikely to set the oscillator to a harmful setting.

Each write is stored as written and masked to the implemented bits, so it reads back as stored. The decoded control outputs come from the stored word. When the stored word holds an unrecognised code, the output falls to a safe default. A write that carries an unrecognised code also latches a sticky error flag in the status word, and writing a one to that bit clears it. The bus is zero-wait-state and never signals an error.

Top module: `osc_key_regs`

## Requirements
- R1: The APB port has zero wait states: `pready` is always 1 and `pslverr` is always 0. A register is written only when `psel`, `penable` and `pwrite` are all high at a rising clock edge, and read data is valid during the access phase.
- R2: After reset the registers read as follows: control 0x00000AA0, both drive registers 0, seed 0x3F04B16D, pause 0x77616B65, divider 0x0000AA20, phase 0x00000008 and status 0x00001000. The outputs are: enabled, range low, all strengths 0, not paused, divide 32, phase output enabled with no flip and no shift.
- R3: The enable field is bits 23:12 of control (offset 0x00). 0xD1E clears `osc_en_o`. 0xFAB sets it. Any other code also sets it and is flagged as bad when written.
- R4: The range field is bits 11:0 of control. The codes map to `range_o` as 0xFA4→0 (low), 0xFA5→1 (medium), 0xFA7→2 (high) and 0xFA6→3 (too high). Any other code gives 0, and writing one is flagged as bad.
- R5: The drive registers are at 0x04 (stages 0–3) and 0x08 (stages 4–7). Each stage k of a register occupies bits 4k+2:4k, and stage n appears on `drive_o[3n+2:3n]`. Bits 3 and 7 of 0x04 drive `rand_o[0]` and `rand_o[1]`. These apply only when bits 31:16 hold 0x9696. With any other key, every strength and randomise output of that register is 0, and writing such a key is flagged as bad.
- R6: The pause register is at 0x10. 0x636F6D61 sets `dormant_o`. 0x77616B65 clears it. Any other word clears it and is flagged as bad when written.
- R7: The divider register is at 0x14. If bits 15:7 equal 0x154 (written values 0xAA00–0xAA7F), `div_o` is bits 6:0, with 0 meaning 128. Any other upper pattern gives 128 and is flagged as bad when written.
- R8: The phase register is at 0x18. If bits 11:4 hold 0xAA, bit 3 is enable, bit 2 is flip and bits 1:0 are shift. Any other key gives enable 1, flip 0 and shift 0, and is flagged as bad when written.
- R9: The status register is at 0x1C. Bit 24 is the sticky bad-write flag and is cleared only by a write with bit 24 set. Bit 12 mirrors `osc_en_o`. Writes to the seed or status registers never set the flag.
- R10: The seed register at 0x0C is a plain 32-bit read/write register whose value drives `seed_o`.
- R11: An address at or beyond 0x20 reads as zero, and a write to it changes no register, output or flag.
- R12: A register reads back its stored word masked to its implemented bits: control 0x00FFFFFF, drive 0x04 0xFFFF77FF, drive 0x08 0xFFFF7777, divider 0x0000FFFF and phase 0x00000FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never errors |
| osc_en_o | output | 1 | Decoded oscillator enable |
| range_o | output | 2 | Decoded range, 0 low to 3 too high |
| drive_o | output | NUM_STAGES*DS_W | Per-stage drive strengths |
| rand_o | output | 2 | Randomise requests for stages 0 and 1 |
| seed_o | output | 32 | Randomiser seed |
| dormant_o | output | 1 | Pause request |
| div_o | output | 8 | Divide ratio 1 to 128 |
| ph_en_o | output | 1 | Phase output enable |
| ph_flip_o | output | 1 | Phase output invert |
| ph_shift_o | output | 2 | Phase shift in input clocks |

## Verification
Each keyed field gets three kinds of write: every recognised code, a word one key bit away from valid, and a word whose data bits are all ones or masked. This separates correct decoding from mere storage and exposes a wrong mask. The flag is read after every write and then cleared. This distinguishes a field that falls back silently from one that also reports, and a clear that works from a flag stuck high. The bench also writes zero to the status bit, performs a setup-only access and writes to an unmapped address. These show whether anything other than a completed, mapped, keyed write changes state.

// File: rtl/osc_key_pkg.sv
package osc_key_pkg;

   localparam logic [11:0] EN_OFF     = 12'hD1E;
   localparam logic [11:0] EN_ON      = 12'hFAB;
   localparam logic [11:0] RNG_LOW    = 12'hFA4;
   localparam logic [11:0] RNG_MED    = 12'hFA5;
   localparam logic [11:0] RNG_HIGH   = 12'hFA7;
   localparam logic [11:0] RNG_OVER   = 12'hFA6;
   localparam logic [15:0] DRV_KEY    = 16'h9696;
   localparam logic [31:0] DORM_SLEEP = 32'h636F6D61;
   localparam logic [31:0] DORM_RUN   = 32'h77616B65;
   localparam logic [8:0]  DIV_TAG    = 9'h154;
   localparam logic [7:0]  PH_KEY     = 8'hAA;

   localparam int NUM_REGS = 8;

   typedef enum logic [2:0] {
      IDX_CTRL   = 3'd0,
      IDX_DRV_LO = 3'd1,
      IDX_DRV_HI = 3'd2,
      IDX_SEED   = 3'd3,
      IDX_DORM   = 3'd4,
      IDX_DIV    = 3'd5,
      IDX_PHASE  = 3'd6,
      IDX_STAT   = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      RSEL_LOW  = 2'd0,
      RSEL_MED  = 2'd1,
      RSEL_HIGH = 2'd2,
      RSEL_OVER = 2'd3
   } range_e;

   typedef struct packed {
      logic   ok;
      range_e sel;
   } range_dec_t;

   function automatic range_dec_t rng_decode(input logic [11:0] code);
      range_dec_t r;
      r.ok  = 1'b1;
      r.sel = RSEL_LOW;
      case (code)
         RNG_LOW:  r.sel = RSEL_LOW;
         RNG_MED:  r.sel = RSEL_MED;
         RNG_HIGH: r.sel = RSEL_HIGH;
         RNG_OVER: r.sel = RSEL_OVER;
         default:  r.ok  = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic en_code_ok(input logic [11:0] code);
      return (code == EN_OFF) || (code == EN_ON);
   endfunction

endpackage

// File: rtl/osc_apb_port.sv
module osc_apb_port #(
   parameter int ADDR_W   = 6,
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int WORD_W  = ADDR_W - 2
) (
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   output logic [NUM_REGS-1:0] wr_stb,
   output logic [IDX_W-1:0]    rd_idx,
   output logic                rd_hit
);

   if (WORD_W < IDX_W) begin : g_addr_chk
      $error("osc_apb_port: address too narrow for register count");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_pow2_chk
      $error("osc_apb_port: register count must be a power of two");
   end

   logic [WORD_W-1:0] word;
   logic              unused_lsbs;
   logic              wr_go;

   assign word        = paddr[ADDR_W-1:2];
   assign unused_lsbs = ^paddr[1:0];
   assign rd_idx      = word[IDX_W-1:0];

   if (WORD_W == IDX_W) begin : g_exact
      assign rd_hit = 1'b1;
   end else begin : g_wide
      assign rd_hit = (word[WORD_W-1:IDX_W] == '0);
   end

   assign wr_go = psel & penable & pwrite & rd_hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
      assign wr_stb[i] = wr_go && (rd_idx == IDX_W'(i));
   end

endmodule

// File: rtl/osc_drive_reg.sv
module osc_drive_reg
   import osc_key_pkg::*;
#(
   parameter int NSTG     = 4,
   parameter int DS_W     = 3,
   parameter bit HAS_RAND = 1'b1,
   localparam int LANE_W  = 4,
   localparam int OUT_W   = NSTG * DS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      raw_o,
   output logic [OUT_W-1:0] ds_o,
   output logic [1:0]       rand_o,
   output logic             bad_o
);

   if (NSTG * LANE_W > 16) begin : g_fit_chk
      $error("osc_drive_reg: stages do not fit below the key");
   end
   if (DS_W > LANE_W - 1) begin : g_ds_chk
      $error("osc_drive_reg: strength field overlaps randomise bit");
   end

   function automatic logic [31:0] keep_mask();
      logic [31:0] m;
      m = 32'hFFFF_0000;
      for (int s = 0; s < NSTG; s++) begin
         m[s*LANE_W +: DS_W] = '1;
         if (HAS_RAND && s < 2) m[s*LANE_W + LANE_W - 1] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [31:0] MASK = keep_mask();

   logic [31:0] raw_q;
   logic        key_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    raw_q <= '0;
      else if (wr_i) raw_q <= wdata_i & MASK;
   end

   assign raw_o  = raw_q;
   assign key_ok = (raw_q[31:16] == DRV_KEY);
   assign bad_o  = wr_i && (wdata_i[31:16] != DRV_KEY);

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      assign ds_o[s*DS_W +: DS_W] = key_ok ? raw_q[s*LANE_W +: DS_W] : '0;
   end

   if (HAS_RAND) begin : g_rand
      assign rand_o = key_ok ? {raw_q[LANE_W + LANE_W - 1], raw_q[LANE_W - 1]} : 2'b00;
   end else begin : g_norand
      assign rand_o = 2'b00;
   end

   AST_DRV_BADKEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[31:16] != DRV_KEY) |=> (ds_o == '0 && rand_o == 2'b00)); // R5

   AST_DRV_GOODKEY_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[31:16] == DRV_KEY) |=> (ds_o[DS_W-1:0] == $past(wdata_i[DS_W-1:0]))); // R5

endmodule

// File: rtl/osc_bad_flag.sv
module osc_bad_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R9

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o)); // R9

endmodule

// File: rtl/osc_key_regs.sv
module osc_key_regs
   import osc_key_pkg::*;
#(
   parameter int          ADDR_W     = 6,
   parameter logic [31:0] SEED_RESET = 32'h3F04B16D,
   parameter int          DIV_RESET  = 32,
   parameter int          NUM_STAGES = 8,
   parameter int          DS_W       = 3,
   localparam int         IDX_W      = $clog2(NUM_REGS),
   localparam int         BANK_STG   = NUM_STAGES / 2,
   localparam int         BANK_W     = BANK_STG * DS_W,
   localparam int         DRV_W      = NUM_STAGES * DS_W
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              osc_en_o,
   output logic [1:0]        range_o,
   output logic [DRV_W-1:0]  drive_o,
   output logic [1:0]        rand_o,
   output logic [31:0]       seed_o,
   output logic              dormant_o,
   output logic [7:0]        div_o,
   output logic              ph_en_o,
   output logic              ph_flip_o,
   output logic [1:0]        ph_shift_o
);

   if (NUM_STAGES % 2 != 0 || BANK_STG > 4) begin : g_stage_chk
      $error("osc_key_regs: stages must split into two banks of at most four");
   end
   if (DIV_RESET < 1 || DIV_RESET > 128) begin : g_div_chk
      $error("osc_key_regs: divider reset out of range");
   end

   localparam logic [23:0] CTRL_RST    = 24'h000AA0;
   localparam logic [11:0] PH_RST      = 12'h008;
   localparam logic [6:0]  DIV_LOW_RST = 7'(DIV_RESET % 128);
   localparam logic [15:0] DIV_RST     = {DIV_TAG, DIV_LOW_RST};

   // bus decode
   logic [NUM_REGS-1:0] wr_stb;
   logic [IDX_W-1:0]    rd_idx;
   logic                rd_hit;

   osc_apb_port #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_port (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .wr_stb  (wr_stb),
      .rd_idx  (rd_idx),
      .rd_hit  (rd_hit)
   );

   // plain keyed registers
   logic [23:0] ctrl_q;
   logic [31:0] seed_q;
   logic [31:0] dorm_q;
   logic [15:0] div_q;
   logic [11:0] ph_q;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ctrl_q <= CTRL_RST;
         seed_q <= SEED_RESET;
         dorm_q <= DORM_RUN;
         div_q  <= DIV_RST;
         ph_q   <= PH_RST;
      end else begin
         if (wr_stb[IDX_CTRL])  ctrl_q <= pwdata[23:0];
         if (wr_stb[IDX_SEED])  seed_q <= pwdata;
         if (wr_stb[IDX_DORM])  dorm_q <= pwdata;
         if (wr_stb[IDX_DIV])   div_q  <= pwdata[15:0];
         if (wr_stb[IDX_PHASE]) ph_q   <= pwdata[11:0];
      end
   end

   // drive-strength banks
   logic [31:0] drv_raw [2];
   logic [1:0]  drv_rand [2];
   logic [1:0]  drv_bad;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      osc_drive_reg #(
         .NSTG     (BANK_STG),
         .DS_W     (DS_W),
         .HAS_RAND (b == 0)
      ) u_drv (
         .clk     (pclk),
         .rst_n   (presetn),
         .wr_i    (wr_stb[int'(IDX_DRV_LO) + b]),
         .wdata_i (pwdata),
         .raw_o   (drv_raw[b]),
         .ds_o    (drive_o[b*BANK_W +: BANK_W]),
         .rand_o  (drv_rand[b]),
         .bad_o   (drv_bad[b])
      );
   end

   assign rand_o = drv_rand[0] | drv_rand[1];

   // output decode
   range_dec_t rng_now;
   logic       ph_ok;
   logic       div_ok;

   assign rng_now   = rng_decode(ctrl_q[11:0]);
   assign range_o   = rng_now.sel;
   assign osc_en_o  = (ctrl_q[23:12] != EN_OFF);
   assign seed_o    = seed_q;
   assign dormant_o = (dorm_q == DORM_SLEEP);

   assign div_ok = (div_q[15:7] == DIV_TAG);
   always_comb begin
      if (div_ok && div_q[6:0] != 7'd0) div_o = {1'b0, div_q[6:0]};
      else                              div_o = 8'd128;
   end

   assign ph_ok      = (ph_q[11:4] == PH_KEY);
   assign ph_en_o    = ph_ok ? ph_q[3]   : 1'b1;
   assign ph_flip_o  = ph_ok ? ph_q[2]   : 1'b0;
   assign ph_shift_o = ph_ok ? ph_q[1:0] : 2'b00;

   // bad-write detection on the incoming word
   range_dec_t rng_wr;
   logic       bad_set;
   logic       bad_clr;
   logic       bad_flag;

   assign rng_wr = rng_decode(pwdata[11:0]);

   always_comb begin
      bad_set = |drv_bad;
      if (wr_stb[IDX_CTRL] && (!en_code_ok(pwdata[23:12]) || !rng_wr.ok))
         bad_set = 1'b1;
      if (wr_stb[IDX_DORM] && pwdata != DORM_SLEEP && pwdata != DORM_RUN)
         bad_set = 1'b1;
      if (wr_stb[IDX_DIV] && pwdata[15:7] != DIV_TAG)
         bad_set = 1'b1;
      if (wr_stb[IDX_PHASE] && pwdata[11:4] != PH_KEY)
         bad_set = 1'b1;
   end

   assign bad_clr = wr_stb[IDX_STAT] && pwdata[24];

   osc_bad_flag u_flag (
      .clk    (pclk),
      .rst_n  (presetn),
      .set_i  (bad_set),
      .clr_i  (bad_clr),
      .flag_o (bad_flag)
   );

   // read path
   logic [31:0] rd_mux;

   always_comb begin
      case (reg_idx_e'(rd_idx))
         IDX_CTRL:   rd_mux = {8'h00, ctrl_q};
         IDX_DRV_LO: rd_mux = drv_raw[0];
         IDX_DRV_HI: rd_mux = drv_raw[1];
         IDX_SEED:   rd_mux = seed_q;
         IDX_DORM:   rd_mux = dorm_q;
         IDX_DIV:    rd_mux = {16'h0000, div_q};
         IDX_PHASE:  rd_mux = {20'h00000, ph_q};
         IDX_STAT:   rd_mux = {7'd0, bad_flag, 11'd0, osc_en_o, 12'd0};
         default:    rd_mux = 32'h0;
      endcase
   end

   assign prdata  = (psel && rd_hit) ? rd_mux : 32'h0;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !rd_hit) |-> (prdata == 32'h0)); // R11

   AST_CTRL_OFF: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_stb[IDX_CTRL] && pwdata[23:12] == EN_OFF) |=> !osc_en_o); // R3

   AST_DORM_BAD_WAKE: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_stb[IDX_DORM] && pwdata != DORM_SLEEP) |=> !dormant_o); // R6

   AST_DIV_IN_RANGE: assert property (@(posedge pclk) disable iff (!presetn)
      (div_o != 8'd0) && (div_o <= 8'd128)); // R7

   AST_PH_BAD_DEFAULT: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_stb[IDX_PHASE] && pwdata[11:4] != PH_KEY) |=>
         (ph_en_o && !ph_flip_o && ph_shift_o == 2'b00)); // R8

   AST_STATUS_NO_SET: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_stb[IDX_STAT] || wr_stb[IDX_SEED]) |-> !bad_set); // R9

endmodule

// File: tb/tb_osc_key_regs.sv
module tb_osc_key_regs;

   localparam int ADDR_W = 6;
   localparam int DRV_W  = 24;

   logic              pclk = 1'b0;
   logic              presetn = 1'b0;
   logic              psel = 1'b0;
   logic              penable = 1'b0;
   logic              pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [31:0]       pwdata = '0;
   logic [31:0]       prdata;
   logic              pready;
   logic              pslverr;
   logic              osc_en_o;
   logic [1:0]        range_o;
   logic [DRV_W-1:0]  drive_o;
   logic [1:0]        rand_o;
   logic [31:0]       seed_o;
   logic              dormant_o;
   logic [7:0]        div_o;
   logic              ph_en_o;
   logic              ph_flip_o;
   logic [1:0]        ph_shift_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 pclk = ~pclk;

   osc_key_regs #(.ADDR_W(ADDR_W)) dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .osc_en_o(osc_en_o),
      .range_o(range_o), .drive_o(drive_o), .rand_o(rand_o),
      .seed_o(seed_o), .dormant_o(dormant_o), .div_o(div_o),
      .ph_en_o(ph_en_o), .ph_flip_o(ph_flip_o), .ph_shift_o(ph_shift_o)
   );

   // {req, addr, wdata, expected readback, expected flag}
   localparam logic [76:0] VEC [16] = '{
      {4'd3,  8'h00, 32'h00FABFA5, 32'h00FABFA5, 1'b0}, // R3 R4 valid pair
      {4'd3,  8'h00, 32'h00D1EFA6, 32'h00D1EFA6, 1'b0}, // R3 disable code
      {4'd3,  8'h00, 32'h00123FA4, 32'h00123FA4, 1'b1}, // R3 bad enable code
      {4'd12, 8'h00, 32'hFFFABAA0, 32'h00FABAA0, 1'b1}, // R12 R4 bad range, upper masked
      {4'd12, 8'h04, 32'h96967FFF, 32'h969677FF, 1'b0}, // R12 R5 low bank mask
      {4'd5,  8'h04, 32'h12345555, 32'h12345555, 1'b1}, // R5 wrong key
      {4'd12, 8'h08, 32'h9696FFFF, 32'h96967777, 1'b0}, // R12 high bank mask
      {4'd10, 8'h0C, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0}, // R10 seed
      {4'd6,  8'h10, 32'h636F6D61, 32'h636F6D61, 1'b0}, // R6 pause word
      {4'd6,  8'h10, 32'h00000001, 32'h00000001, 1'b1}, // R6 bad word
      {4'd7,  8'h14, 32'hFFFFAA05, 32'h0000AA05, 1'b0}, // R7 R12 divider mask
      {4'd7,  8'h14, 32'h0000AB05, 32'h0000AB05, 1'b1}, // R7 bad tag
      {4'd8,  8'h18, 32'h00000AAD, 32'h00000AAD, 1'b0}, // R8 good key
      {4'd8,  8'h18, 32'h00000F0F, 32'h00000F0F, 1'b1}, // R8 bad key
      {4'd9,  8'h1C, 32'h00000000, 32'h00001000, 1'b0}, // R9 status write, no set
      {4'd11, 8'h20, 32'hFFFFFFFF, 32'h00000000, 1'b0}  // R11 unmapped
   };

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata;
      check("R1 pready", {31'd0, pready}, 32'd1);
      check("R1 pslverr", {31'd0, pslverr}, 32'd0);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
      logic [31:0] d;
      apb_read(a, d);
      check(tag, d, exp);
   endtask

   initial begin
      repeat (100000) @(posedge pclk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);

      // R2 reset state
      check("R2 osc_en", {31'd0, osc_en_o}, 32'd1);
      check("R2 range", {30'd0, range_o}, 32'd0);
      check("R2 drive", {8'd0, drive_o}, 32'd0);
      check("R2 rand", {30'd0, rand_o}, 32'd0);
      check("R2 dormant", {31'd0, dormant_o}, 32'd0);
      check("R2 div", {24'd0, div_o}, 32'd32);
      check("R2 phase", {28'd0, ph_en_o, ph_flip_o, ph_shift_o}, 32'h8);
      check("R2 seed", seed_o, 32'h3F04B16D);
      read_check("R2 ctrl", 6'h00, 32'h00000AA0);
      read_check("R2 drv lo", 6'h04, 32'h0);
      read_check("R2 drv hi", 6'h08, 32'h0);
      read_check("R2 seed rd", 6'h0C, 32'h3F04B16D);
      read_check("R2 dormant rd", 6'h10, 32'h77616B65);
      read_check("R2 div rd", 6'h14, 32'h0000AA20);
      read_check("R2 phase rd", 6'h18, 32'h00000008);
      read_check("R2 status", 6'h1C, 32'h00001000);

      // vector table
      for (int i = 0; i < 16; i++) begin
         logic [76:0] v;
         string tg;
         v = VEC[i];
         tg = $sformatf("R%0d vec%0d", v[76:73], i);
         apb_write(v[70:65], v[64:33]);
         apb_read(v[70:65], rd);
         check({tg, " readback"}, rd, v[32:1]);
         apb_read(6'h1C, rd);
         check({tg, " flag"}, {31'd0, rd[24]}, {31'd0, v[0]});
         apb_write(6'h1C, 32'h01000000);
      end

      // R3 R4 decoded control
      apb_write(6'h00, 32'h00D1EFA7);
      check("R3 disabled", {31'd0, osc_en_o}, 32'd0);
      check("R4 high", {30'd0, range_o}, 32'd2);
      read_check("R9 status en mirror", 6'h1C, 32'h00000000);
      apb_write(6'h00, 32'h00FABFA6);
      check("R3 enabled", {31'd0, osc_en_o}, 32'd1);
      check("R4 too high", {30'd0, range_o}, 32'd3);
      apb_write(6'h00, 32'h00FABFA5);
      check("R4 medium", {30'd0, range_o}, 32'd1);
      apb_write(6'h00, 32'h00777123);
      check("R3 bad enables", {31'd0, osc_en_o}, 32'd1);
      check("R4 bad low", {30'd0, range_o}, 32'd0);

      // R5 drive strengths
      apb_write(6'h04, 32'h96964AB1);
      apb_write(6'h08, 32'h96967777);
      check("R5 both banks", {8'd0, drive_o}, 32'h00FFF899);
      check("R5 rand", {30'd0, rand_o}, 32'd2);
      apb_write(6'h08, 32'h00007777);
      check("R5 bad key zeroes", {8'd0, drive_o}, 32'h00000899);

      // R6 pause
      apb_write(6'h10, 32'h636F6D61);
      check("R6 pause", {31'd0, dormant_o}, 32'd1);
      apb_write(6'h10, 32'h77616B65);
      check("R6 wake", {31'd0, dormant_o}, 32'd0);

      // R7 divider corners
      apb_write(6'h14, 32'h0000AA00);
      check("R7 zero is 128", {24'd0, div_o}, 32'd128);
      apb_write(6'h14, 32'h0000AA01);
      check("R7 one", {24'd0, div_o}, 32'd1);
      apb_write(6'h14, 32'h0000AA7F);
      check("R7 max", {24'd0, div_o}, 32'd127);
      apb_write(6'h14, 32'h0000AB05);
      check("R7 bad tag", {24'd0, div_o}, 32'd128);
      apb_write(6'h14, 32'h0000AA20);

      // R8 phase
      apb_write(6'h18, 32'h00000AA6);
      check("R8 keyed", {28'd0, ph_en_o, ph_flip_o, ph_shift_o}, 32'h6);
      apb_write(6'h18, 32'h000005A6);
      check("R8 fallback", {28'd0, ph_en_o, ph_flip_o, ph_shift_o}, 32'h8);

      // R9 sticky flag
      apb_write(6'h1C, 32'h00FFFFFF);
      read_check("R9 zero bit keeps flag", 6'h1C, 32'h01001000);
      apb_write(6'h1C, 32'h01000000);
      read_check("R9 cleared", 6'h1C, 32'h00001000);

      // R10 seed output
      apb_write(6'h0C, 32'h13579BDF);
      check("R10 seed out", seed_o, 32'h13579BDF);

      // R1 setup-only access does not write
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = 6'h14; pwdata = 32'h0000AA03; penable = 1'b0;
      @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      check("R1 setup only", {24'd0, div_o}, 32'd32);

      // R11 unmapped write
      apb_write(6'h3C, 32'h0000AA03);
      read_check("R11 unmapped read", 6'h3C, 32'h0);
      read_check("R11 div intact", 6'h14, 32'h0000AA20);
      read_check("R11 flag intact", 6'h1C, 32'h00001000);
      check("R11 div out", {24'd0, div_o}, 32'd32);

      done = 1'b1;
      report();
      $finish;
   end

endmodule